// File: doc/BRIEF.md
# Chained FIR Filter Pair with Shared Coefficient Pool

This block runs two finite impulse response filters in series. Filter A takes a stream of signed samples. Each output of filter A becomes the next input of filter Y. Each filter forms the direct convolution of its recent inputs with its own coefficient set. It does one multiply-accumulate per clock. It keeps the full sum at full precision and then rounds and saturates the result back to the sample width. Each filter stores its input history in a 256-slot ring.

Both coefficient sets sit in one pool of 255 entries. The two tap counts together must fit in that pool. The pool is filled by a burst writer: a start pulse sends the write address back to entry 0, and each accepted write stores one word and moves the address up by one. Filter A's coefficients are written first and filter Y's follow. A write presented while either filter is computing is held off until both are idle. A tap-count configuration that does not fit the pool is refused and flagged.

A sync pulse sets time zero for both filters. It abandons any computation in progress and sends each ring's write slot back to slot 0. It does not clear the stored samples, so the first outputs after sync combine old and new data. If a sample arrives in the same cycle as sync, the sample is dropped. Samples are expected at least tA+tB+3 cycles apart. A sample offered while a filter is still computing is not taken.

Top module: `fir_pair`

## Requirements
- R1: Filter A computes a_data = round_sat(sum over k in 0..tA-1 of h[k]·X(n−k)). Here h[k] is pool entry k in signed Q1.15 form, X(n) is the newest input, and tA is the accepted A tap count.
- R2: Filter Y's input is each filter A output. Filter Y uses pool entries tA..tA+tB−1 in the same convolution form to produce y_data.
- R3: round_sat adds 2^14 to the sum and shifts it right arithmetically by 15 bits. It then clamps the result to the range −32768..32767.
- R4: a_valid is a one-cycle pulse. It appears tA clock edges after the edge that accepted in_valid. y_valid is a one-cycle pulse that appears tB+1 edges after a_valid.
- R5: coef_start sends the write address to 0. Each accepted write stores coef_wr_data at the address and then increments it. Writes after entry 254 has been filled are dropped and do not wrap.
- R6: coef_wr_ready is low while either filter is computing. A coef_wr_en given while coef_wr_ready is low stores nothing.
- R7: cfg_load with cfg_taps_a ≥ 1, cfg_taps_b ≥ 1 and a sum of at most 255 is accepted, and cfg_err clears on the next cycle. Any other cfg_load is refused: cfg_err is set on the next cycle and the previous tap counts stay in use.
- R8: A sync_in pulse drops any computation in progress, with no output pulse from it. It also sends both rings' write slot to 0, so the next sample goes into slot 0.
- R9: Sync does not clear the history. X(n−k) is read from ring slot (w−k) mod 256, where w is the newest sample's slot. Outputs after sync therefore mix pre-sync and post-sync samples.
- R10: After reset, all history slots are zero, both tap counts are 1, a_valid, y_valid and cfg_err are low, and coef_wr_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe for filter A |
| in_data | input | 16 | Signed input sample |
| coef_start | input | 1 | Return coefficient write address to 0 |
| coef_wr_en | input | 1 | Coefficient write request |
| coef_wr_data | input | 16 | Signed Q1.15 coefficient |
| coef_wr_ready | output | 1 | High when a write will be accepted |
| cfg_load | input | 1 | Apply the tap counts |
| cfg_taps_a | input | 8 | Requested tap count, filter A |
| cfg_taps_b | input | 8 | Requested tap count, filter Y |
| cfg_err | output | 1 | Last configuration was refused |
| sync_in | input | 1 | Time-zero pulse |
| a_valid | output | 1 | Filter A result strobe |
| a_data | output | 16 | Filter A result |
| y_valid | output | 1 | Filter Y result strobe |
| y_data | output | 16 | Filter Y result |

## Verification
A wrong ring slot or coefficient address shows on the very next result strobe, as a value that differs from the convolution of the modelled history. A sync error therefore shows on the first sample after the pulse. A wrong tap counter moves the result strobe off its expected cycle, and that is visible within tA edges. A write taken during a computation shifts the pool address, so it appears only in the next output that uses the displaced entries. Sample histories are long, so the stream has to wrap the ring before a stale slot can be told apart from a zeroed one.

// File: rtl/fir_pair_pkg.sv
// Shared sizes, types and the output rounding function for the chained filter pair.
// Assumes two's-complement Q1.15 coefficients and a pool no larger than the ring depth minus one.
package fir_pair_pkg;

    localparam int DATA_W   = 16;
    localparam int COEF_W   = 16;
    localparam int POOL     = 255;
    localparam int GUARD_W  = 8;
    localparam int NUM_FILT = 2;

    localparam int PAW    = $clog2(POOL + 1);
    localparam int HDEPTH = 2 ** PAW;
    localparam int FRAC   = COEF_W - 1;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic        [PAW-1:0]    idx_t;

    // Round half up at the binary point, then clamp to the sample range.
    function automatic sample_t round_sat(input acc_t acc);
        logic signed [ACC_W:0] biased;
        logic signed [ACC_W:0] scaled;
        logic signed [ACC_W:0] hi;
        logic signed [ACC_W:0] lo;
        hi     = (ACC_W + 1)'(2 ** (DATA_W - 1) - 1);
        lo     = ~hi;
        biased = $signed({acc[ACC_W-1], acc}) + ((ACC_W + 1)'(1) << (FRAC - 1));
        scaled = biased >>> FRAC;
        if (scaled > hi) begin
            return {1'b0, {(DATA_W - 1){1'b1}}};
        end
        if (scaled < lo) begin
            return {1'b1, {(DATA_W - 1){1'b0}}};
        end
        return scaled[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/fir_coef_pool.sv
// Coefficient pool shared by all filters, filled by an auto-incrementing burst writer.
// Assumes wr_allow is low whenever any filter reads the pool; reads are combinational.
module fir_coef_pool
    import fir_pair_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_start,
    input  logic  wr_en,
    input  logic  wr_allow,
    input  coef_t wr_data,
    input  idx_t  rd_addr [NUM_FILT],
    output coef_t rd_data [NUM_FILT]
);

    coef_t mem [HDEPTH];
    idx_t  wr_ptr;
    logic  wr_fire;

    assign wr_fire = wr_en && wr_allow && !wr_start && (wr_ptr < idx_t'(POOL));

    // Write address: back to zero on start, step on each stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_start) begin
            wr_ptr <= '0;
        end else if (wr_fire) begin
            wr_ptr <= wr_ptr + idx_t'(1);
        end
    end

    // Storage: one word written per accepted request.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_FILT; g++) begin : g_rd
            assign rd_data[g] = mem[rd_addr[g]];
        end
    endgenerate

endmodule

// File: rtl/fir_tap_cfg.sv
// Holds the accepted tap counts and refuses any pair that does not fit the pool.
// Assumes both requested counts arrive together with a one-cycle load strobe.
module fir_tap_cfg
    import fir_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  idx_t req_a,
    input  idx_t req_b,
    output idx_t taps_a,
    output idx_t taps_b,
    output logic err
);

    logic [PAW:0] req_sum;
    logic         fits;

    assign req_sum = {1'b0, req_a} + {1'b0, req_b};
    assign fits    = (req_a != '0) && (req_b != '0) && (req_sum <= (PAW + 1)'(POOL));

    // Configuration register: take a fitting pair, otherwise keep the old one and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_a <= idx_t'(1);
            taps_b <= idx_t'(1);
            err    <= 1'b0;
        end else if (load) begin
            if (fits) begin
                taps_a <= req_a;
                taps_b <= req_b;
                err    <= 1'b0;
            end else begin
                err    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fir_core.sv
// One filter: a 256-slot sample ring and a serial multiply-accumulate of one tap per clock.
// Assumes a new sample only arrives while idle; tap count and pool base are latched per sample.
module fir_core
    import fir_pair_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sync,
    input  logic    s_valid,
    input  sample_t s_data,
    input  idx_t    n_taps,
    input  idx_t    c_base,
    output idx_t    c_addr,
    input  coef_t   c_data,
    output logic    busy,
    output logic    o_valid,
    output sample_t o_data
);

    sample_t hist [HDEPTH];
    idx_t    wr_slot;
    idx_t    rd_slot;
    idx_t    tap_idx;
    idx_t    taps_q;
    idx_t    base_q;
    acc_t    acc_q;
    prod_t   prod;
    acc_t    acc_nxt;
    logic    last_tap;

    // Datapath: product of the current tap and its sample, added to the running sum.
    always_comb begin
        prod     = prod_t'(c_data) * prod_t'(hist[rd_slot]);
        acc_nxt  = acc_q + acc_t'(prod);
        last_tap = (tap_idx == taps_q - idx_t'(1));
    end

    assign c_addr = base_q + tap_idx;

    // Sequencer: store the sample, walk the taps backwards through the ring, emit one result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDEPTH; i++) begin
                hist[i] <= '0;
            end
            wr_slot <= '0;
            rd_slot <= '0;
            tap_idx <= '0;
            taps_q  <= idx_t'(1);
            base_q  <= '0;
            acc_q   <= '0;
            busy    <= 1'b0;
            o_valid <= 1'b0;
            o_data  <= '0;
        end else if (sync) begin
            wr_slot <= '0;
            tap_idx <= '0;
            acc_q   <= '0;
            busy    <= 1'b0;
            o_valid <= 1'b0;
        end else begin
            o_valid <= 1'b0;
            if (busy) begin
                acc_q   <= acc_nxt;
                rd_slot <= rd_slot - idx_t'(1);
                tap_idx <= tap_idx + idx_t'(1);
                if (last_tap) begin
                    busy    <= 1'b0;
                    o_valid <= 1'b1;
                    o_data  <= round_sat(acc_nxt);
                end
            end else if (s_valid) begin
                hist[wr_slot] <= s_data;
                rd_slot       <= wr_slot;
                wr_slot       <= wr_slot + idx_t'(1);
                tap_idx       <= '0;
                acc_q         <= '0;
                taps_q        <= n_taps;
                base_q        <= c_base;
                busy          <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fir_pair.sv
// Two filters in series sharing one coefficient pool, with tap-count checking and sync.
// Assumes samples are spaced far enough apart for both filters to finish between them.
module fir_pair
    import fir_pair_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     coef_start,
    input  logic                     coef_wr_en,
    input  logic signed [COEF_W-1:0] coef_wr_data,
    output logic                     coef_wr_ready,
    input  logic                     cfg_load,
    input  logic        [PAW-1:0]    cfg_taps_a,
    input  logic        [PAW-1:0]    cfg_taps_b,
    output logic                     cfg_err,
    input  logic                     sync_in,
    output logic                     a_valid,
    output logic signed [DATA_W-1:0] a_data,
    output logic                     y_valid,
    output logic signed [DATA_W-1:0] y_data
);

    logic    st_valid [NUM_FILT];
    sample_t st_data  [NUM_FILT];
    logic    o_valid  [NUM_FILT];
    sample_t o_data   [NUM_FILT];
    logic    busy     [NUM_FILT];
    idx_t    c_addr   [NUM_FILT];
    coef_t   c_data   [NUM_FILT];
    idx_t    tap_cnt  [NUM_FILT];
    idx_t    c_base   [NUM_FILT];
    logic    any_busy;

    // Idle detect: the pool may only be written when no filter is reading it.
    always_comb begin
        any_busy = 1'b0;
        for (int i = 0; i < NUM_FILT; i++) begin
            any_busy = any_busy | busy[i];
        end
    end

    assign coef_wr_ready = !any_busy;

    fir_tap_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .req_a  (cfg_taps_a),
        .req_b  (cfg_taps_b),
        .taps_a (tap_cnt[0]),
        .taps_b (tap_cnt[1]),
        .err    (cfg_err)
    );

    fir_coef_pool u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (coef_start),
        .wr_en    (coef_wr_en),
        .wr_allow (coef_wr_ready),
        .wr_data  (coef_wr_data),
        .rd_addr  (c_addr),
        .rd_data  (c_data)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_FILT; g++) begin : g_filt
            if (g == 0) begin : g_head
                assign st_valid[g] = in_valid;
                assign st_data[g]  = in_data;
                assign c_base[g]   = '0;
            end else begin : g_link
                assign st_valid[g] = o_valid[g-1];
                assign st_data[g]  = o_data[g-1];
                assign c_base[g]   = c_base[g-1] + tap_cnt[g-1];
            end

            fir_core u_core (
                .clk     (clk),
                .rst_n   (rst_n),
                .sync    (sync_in),
                .s_valid (st_valid[g]),
                .s_data  (st_data[g]),
                .n_taps  (tap_cnt[g]),
                .c_base  (c_base[g]),
                .c_addr  (c_addr[g]),
                .c_data  (c_data[g]),
                .busy    (busy[g]),
                .o_valid (o_valid[g]),
                .o_data  (o_data[g])
            );
        end
    endgenerate

    assign a_valid = o_valid[0];
    assign a_data  = o_data[0];
    assign y_valid = o_valid[NUM_FILT-1];
    assign y_data  = o_data[NUM_FILT-1];

endmodule

// File: rtl/fir_pair_chk.sv
// Port-level properties of the filter pair, attached to every instance by bind.
// Assumes the same package sizes as the design it observes.
module fir_pair_chk
    import fir_pair_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           a_valid,
    input logic           y_valid,
    input logic           coef_wr_ready,
    input logic           cfg_load,
    input logic [PAW-1:0] cfg_taps_a,
    input logic [PAW-1:0] cfg_taps_b,
    input logic           cfg_err,
    input logic           sync_in
);

    logic [PAW:0] req_sum;
    logic         req_bad;

    assign req_sum = {1'b0, cfg_taps_a} + {1'b0, cfg_taps_b};
    assign req_bad = (cfg_taps_a == '0) || (cfg_taps_b == '0) || (req_sum > (PAW + 1)'(POOL));

    p_a_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |=> !a_valid);

    p_y_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid);

    p_a_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_valid) |-> !$past(coef_wr_ready));

    p_y_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_valid) |-> !$past(coef_wr_ready));

    p_cfg_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && req_bad) |=> cfg_err);

    p_cfg_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !req_bad) |=> !cfg_err);

    p_sync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (!a_valid && !y_valid));

endmodule

bind fir_pair fir_pair_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .a_valid       (a_valid),
    .y_valid       (y_valid),
    .coef_wr_ready (coef_wr_ready),
    .cfg_load      (cfg_load),
    .cfg_taps_a    (cfg_taps_a),
    .cfg_taps_b    (cfg_taps_b),
    .cfg_err       (cfg_err),
    .sync_in       (sync_in)
);

// File: tb/fir_pair_test.sv
module fir_pair_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               coef_start = 1'b0;
    logic               coef_wr_en = 1'b0;
    logic signed [15:0] coef_wr_data = '0;
    logic               coef_wr_ready;
    logic               cfg_load = 1'b0;
    logic        [7:0]  cfg_taps_a = '0;
    logic        [7:0]  cfg_taps_b = '0;
    logic               cfg_err;
    logic               sync_in = 1'b0;
    logic               a_valid;
    logic signed [15:0] a_data;
    logic               y_valid;
    logic signed [15:0] y_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    int pool [256];
    int ma [256];
    int mb [256];
    int wa = 0;
    int wb = 0;
    int wptr = 0;
    int ta = 1;
    int tb = 1;
    int last_a = 0;
    int last_y = 0;

    localparam int NSTIM = 12;
    localparam int STIM [NSTIM] = '{1000, 2000, -4000, 32767, -32768, 0,
                                    12345, -777, 5000, 5000, -20000, 300};

    always #2 clk = ~clk;

    fir_pair uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .coef_start(coef_start), .coef_wr_en(coef_wr_en), .coef_wr_data(coef_wr_data),
        .coef_wr_ready(coef_wr_ready), .cfg_load(cfg_load), .cfg_taps_a(cfg_taps_a),
        .cfg_taps_b(cfg_taps_b), .cfg_err(cfg_err), .sync_in(sync_in),
        .a_valid(a_valid), .a_data(a_data), .y_valid(y_valid), .y_data(y_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rs(input longint acc);
        longint r;
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // advance the model by one input sample
    task automatic model_push(input int x, output int ea, output int eb);
        longint acc;
        ma[8'(wa)] = x;
        acc = 0;
        for (int k = 0; k < ta; k++) acc += longint'(pool[8'(k)]) * longint'(ma[8'(wa - k)]);
        ea = rs(acc);
        wa = (wa + 1) & 255;
        mb[8'(wb)] = ea;
        acc = 0;
        for (int k = 0; k < tb; k++) acc += longint'(pool[8'(ta + k)]) * longint'(mb[8'(wb - k)]);
        eb = rs(acc);
        wb = (wb + 1) & 255;
    endtask

    task automatic push(input int x, input string req);
        int ea;
        int eb;
        model_push(x, ea, eb);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (ta) @(posedge clk);
        @(negedge clk);
        check(a_valid == 1'b1, "R4 a_valid timing", int'(a_valid), 1);
        check(int'(a_data) == ea, req, int'(a_data), ea);
        repeat (tb + 1) @(posedge clk);
        @(negedge clk);
        check(a_valid == 1'b0, "R4 a_valid width", int'(a_valid), 0);
        check(y_valid == 1'b1, "R4 y_valid timing", int'(y_valid), 1);
        check(int'(y_data) == eb, "R2 chained output", int'(y_data), eb);
        last_a = int'(a_data);
        last_y = int'(y_data);
    endtask

    task automatic coef_begin();
        @(negedge clk);
        coef_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        coef_start = 1'b0;
        wptr = 0;
    endtask

    task automatic coef_write(input int v);
        @(negedge clk);
        coef_wr_en   = 1'b1;
        coef_wr_data = 16'(v);
        @(posedge clk);
        @(negedge clk);
        coef_wr_en = 1'b0;
        if (wptr < 255) begin
            pool[8'(wptr)] = v;
            wptr++;
        end
    endtask

    task automatic configure(input int a, input int b, input bit exp_err);
        @(negedge clk);
        cfg_load   = 1'b1;
        cfg_taps_a = 8'(a);
        cfg_taps_b = 8'(b);
        @(posedge clk);
        @(negedge clk);
        cfg_load = 1'b0;
        check(cfg_err == exp_err, "R7 cfg_err", int'(cfg_err), int'(exp_err));
        if (!exp_err) begin
            ta = a;
            tb = b;
        end
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        sync_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sync_in = 1'b0;
        check(!a_valid && !y_valid, "R8 quiet after sync", int'(a_valid) + int'(y_valid), 0);
        wa = 0;
        wb = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ea;
        int eb;
        bit rdy;
        for (int i = 0; i < 256; i++) begin
            pool[i] = 0;
            ma[i] = 0;
            mb[i] = 0;
        end

        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!a_valid, "R10 a_valid", int'(a_valid), 0);
        check(!y_valid, "R10 y_valid", int'(y_valid), 0);
        check(!cfg_err, "R10 cfg_err", int'(cfg_err), 0);
        check(coef_wr_ready, "R10 coef_wr_ready", int'(coef_wr_ready), 1);

        // R1/R2: table of samples through a 3-tap and a 2-tap filter
        coef_begin();
        coef_write(16384);
        coef_write(8192);
        coef_write(-8192);
        coef_write(24576);
        coef_write(-16384);
        configure(3, 2, 1'b0);
        for (int i = 0; i < NSTIM; i++) push(STIM[i], "R1 convolution");

        // R3: saturation at both ends
        coef_begin();
        for (int i = 0; i < 5; i++) coef_write(32767);
        for (int i = 0; i < 3; i++) push(30000, "R1 convolution");
        check(last_a == 32767, "R3 positive clamp", last_a, 32767);
        for (int i = 0; i < 3; i++) push(-30000, "R1 convolution");
        check(last_a == -32768, "R3 negative clamp", last_a, -32768);

        // R3: rounding with a single 0.5 tap
        coef_begin();
        coef_write(16384);
        coef_write(0);
        coef_write(0);
        push(1, "R3 rounding");
        check(last_a == 1, "R3 half rounds up", last_a, 1);
        push(-1, "R3 rounding");
        check(last_a == 0, "R3 minus half rounds up", last_a, 0);
        push(3, "R3 rounding");
        check(last_a == 2, "R3 one and a half", last_a, 2);

        // R5: overfilling the pool does not wrap
        coef_begin();
        for (int i = 0; i < 258; i++) begin
            if (i == 0) coef_write(16384);
            else if (i == 1) coef_write(32767);
            else if (i >= 255) coef_write(999);
            else coef_write(((i * 37) % 1000) - 500);
        end
        configure(1, 1, 1'b0);
        push(1000, "R5 pool contents");
        check(last_a == 500, "R5 entry 0 kept", last_a, 500);

        // R6: write held off while filters compute
        coef_begin();
        model_push(2000, ea, eb);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(2000);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(!coef_wr_ready, "R6 ready low while busy", int'(coef_wr_ready), 0);
        coef_wr_en   = 1'b1;
        coef_wr_data = 16'(16384);
        do begin
            rdy = coef_wr_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!rdy);
        coef_wr_en = 1'b0;
        pool[0] = 16384;
        wptr = 1;
        coef_write(-16384);
        push(2000, "R6 pool after held write");
        check(last_y == -500, "R6 single write stored", last_y, -500);

        // R7: refused and accepted configurations
        configure(200, 100, 1'b1);
        push(600, "R7 old taps kept");
        configure(0, 5, 1'b1);
        configure(254, 1, 1'b0);
        configure(254, 2, 1'b1);
        configure(3, 2, 1'b0);

        // R9: wrap the ring, then sync so old slots feed the next result
        for (int i = 0; i < 260; i++) push(((i * 1237) % 20000) - 10000, "R1 convolution");
        sync_pulse();
        push(7000, "R9 mixed history after sync");
        push(-3000, "R9 mixed history after sync");

        // R8: sync during a computation cancels it
        model_push(4321, ea, eb);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(4321);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        sync_in  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sync_in = 1'b0;
        wa = 0;
        wb = 0;
        for (int i = 0; i < 8; i++) begin
            check(!a_valid && !y_valid, "R8 cancelled output", int'(a_valid) + int'(y_valid), 0);
            @(negedge clk);
        end
        push(100, "R8 restart at slot 0");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule